// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform timing for an I2C master. A functional clock drives a programmable divider that yields an internal tick. Each SCL phase, low or high, lasts a programmed field value plus a fixed offset of six ticks. The low-time and high-time configuration words each carry two 8-bit fields. The lower byte holds the count for standard and fast modes. The upper byte holds the count for high-speed operation.

When high-speed operation is chosen, a transfer runs in two stages. The first stage, which sends the master code, uses the standard/fast fields counted on the divided tick. The second stage uses the high-speed fields counted directly on the functional clock, with the divider bypassed. A separate select input chooses the stage. The generator samples that select only when SCL goes from low to high. All timing values are captured at a phase boundary, so a new setting applies from the next phase onwards. The outputs are an SCL pull-low request and one-cycle strobes that mark the start of each low and each high phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While `gen_en` is low, and from the first cycle after `gen_en` is sampled low, `scl_pull_low`, `scl_fall_stb` and `scl_rise_stb` are all 0.
- R2: In the first cycle after `gen_en` is sampled high while the generator is idle, `scl_pull_low` is 1 and `scl_fall_stb` pulses, starting a low phase.
- R3: In standard/fast timing, a low phase lasts (P+1)*(L+6) clock cycles. P is `prescale` and L is `low_cfg[7:0]`.
- R4: In standard/fast timing, a high phase lasts (P+1)*(H+6) clock cycles, where H is `high_cfg[7:0]`.
- R5: `scl_fall_stb` is a one-cycle pulse in the first cycle of every low phase. `scl_rise_stb` is a one-cycle pulse in the first cycle of every high phase. The two are never 1 together.
- R6: `prescale`, `low_cfg` and `high_cfg` are sampled only at a phase boundary, meaning the cycle that starts a phase. A change in the middle of a phase does not alter the length of that phase.
- R7: While `hs_mode` is 0, `hs_phase` has no effect and only the bits [7:0] fields are used.
- R8: When `hs_mode` and `hs_phase` are both 1 at a low-to-high transition, the high-speed stage begins. Its high phase lasts `high_cfg[15:8]`+6 cycles and each low phase after it lasts `low_cfg[15:8]`+6 cycles, with `prescale` ignored. The stage continues until the next low-to-high transition finds either input at 0.
- R9: `hs_mode` and `hs_phase` are sampled only at a low-to-high transition. A change at any other time has no effect until the next such transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator enable |
| hs_mode | input | 1 | High-speed operation allowed |
| hs_phase | input | 1 | Stage select: 1 = high-speed stage, 0 = first (master-code) stage |
| prescale | input | PSC_W | Divider value; tick = clock / (value+1) |
| low_cfg | input | 2*FIELD_W | Low-time fields: [7:0] standard/fast, [15:8] high-speed |
| high_cfg | input | 2*FIELD_W | High-time fields: [7:0] standard/fast, [15:8] high-speed |
| scl_pull_low | output | 1 | Request to drive SCL low |
| scl_fall_stb | output | 1 | Pulse in the first cycle of a low phase |
| scl_rise_stb | output | 1 | Pulse in the first cycle of a high phase |

## Verification
The bench builds the block with its default parameters: 8-bit fields, an 8-bit divider and an offset of 6. With these values the whole field range is reachable in a short run. One case uses a low field of 255 with no division, which gives a 261-cycle phase and tests the widest phase counter. Small divider values from 0 to 3 cover both the divided path and the bypassed path within a few hundred cycles. The reference model samples the configuration and stage inputs only at the boundaries it predicts. Because of that, mid-phase changes to the settings and free toggling of the stage select show up directly as mismatches if the design samples them at the wrong time.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    // SCL level currently generated
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } scl_phase_e;

    // fixed number of ticks added to every programmed phase field
    parameter int SCL_TG_OFFSET_DEF = 6;

endpackage

// File: rtl/scl_tg_prescale.sv
module scl_tg_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bypass,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_d, cnt_q;

    assign tick = bypass || (cnt_q == div);

    always_comb begin
        cnt_d = cnt_q;
        if (clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/scl_tg_span_cnt.sv
module scl_tg_span_cnt #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             done
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    assign done = tick && (cnt_q == (len - LEN_W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || done) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/scl_tg_len_sel.sv
module scl_tg_len_sel #(
    parameter int FIELD_W = 8,
    parameter int OFFSET  = 6,
    parameter int LEN_W   = 9
) (
    input  logic [2*FIELD_W-1:0] cfg,
    input  logic                 use_hs,
    output logic [LEN_W-1:0]     len
);
    logic [FIELD_W-1:0] field;

    always_comb begin
        field = use_hs ? cfg[2*FIELD_W-1:FIELD_W] : cfg[FIELD_W-1:0];
        len   = LEN_W'(field) + LEN_W'(OFFSET);
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int PSC_W   = 8,
    parameter int OFFSET  = SCL_TG_OFFSET_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gen_en,
    input  logic                 hs_mode,
    input  logic                 hs_phase,
    input  logic [PSC_W-1:0]     prescale,
    input  logic [2*FIELD_W-1:0] low_cfg,
    input  logic [2*FIELD_W-1:0] high_cfg,
    output logic                 scl_pull_low,
    output logic                 scl_fall_stb,
    output logic                 scl_rise_stb
);
    localparam int LEN_W = $clog2((1 << FIELD_W) + OFFSET + 1);

    typedef struct packed {
        logic             active;
        scl_phase_e       phase;
        logic             hs_sel;
        logic [PSC_W-1:0] psc;
        logic [LEN_W-1:0] len;
        logic             pull;
        logic             fall;
        logic             rise;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic             tick;
    logic             span_done;
    logic             hs_next;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             hs_active;

    // stage choice captured on the coming low-to-high transition
    assign hs_next   = hs_mode && hs_phase;
    assign hs_active = st_q.hs_sel;

    scl_tg_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!st_q.active),
        .bypass (st_q.hs_sel),
        .div    (st_q.psc),
        .tick   (tick)
    );

    scl_tg_span_cnt #(.LEN_W(LEN_W)) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!st_q.active),
        .tick  (tick),
        .len   (st_q.len),
        .done  (span_done)
    );

    // low phases keep the current stage; high phases use the newly sampled one
    scl_tg_len_sel #(.FIELD_W(FIELD_W), .OFFSET(OFFSET), .LEN_W(LEN_W)) u_low_len (
        .cfg    (low_cfg),
        .use_hs (st_q.hs_sel),
        .len    (low_len)
    );

    scl_tg_len_sel #(.FIELD_W(FIELD_W), .OFFSET(OFFSET), .LEN_W(LEN_W)) u_high_len (
        .cfg    (high_cfg),
        .use_hs (hs_next),
        .len    (high_len)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        st_d.rise = 1'b0;
        if (!gen_en) begin
            st_d = '0;
        end else if (!st_q.active) begin
            st_d.active = 1'b1;
            st_d.phase  = PH_LOW;
            st_d.hs_sel = 1'b0;
            st_d.psc    = prescale;
            st_d.len    = low_len;
            st_d.pull   = 1'b1;
            st_d.fall   = 1'b1;
        end else if (span_done) begin
            st_d.psc = prescale;
            if (st_q.phase == PH_LOW) begin
                st_d.phase  = PH_HIGH;
                st_d.hs_sel = hs_next;
                st_d.len    = high_len;
                st_d.pull   = 1'b0;
                st_d.rise   = 1'b1;
            end else begin
                st_d.phase = PH_LOW;
                st_d.len   = low_len;
                st_d.pull  = 1'b1;
                st_d.fall  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_pull_low = st_q.pull;
    assign scl_fall_stb = st_q.fall;
    assign scl_rise_stb = st_q.rise;
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic scl_pull_low,
    input logic scl_fall_stb,
    input logic scl_rise_stb,
    input logic hs_active
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!scl_pull_low && !scl_fall_stb && !scl_rise_stb));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_fall_stb && scl_rise_stb));

    // R2
    low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> scl_fall_stb);

    // R5
    high_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_pull_low) && $past(gen_en)) |-> scl_rise_stb);

    // R5
    fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |-> scl_pull_low);

    // R5
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_stb |-> !scl_pull_low);

    // R9
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_low && $past(scl_pull_low)) |-> $stable(hs_active));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_en       (gen_en),
    .scl_pull_low (scl_pull_low),
    .scl_fall_stb (scl_fall_stb),
    .scl_rise_stb (scl_rise_stb),
    .hs_active    (hs_active)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
    localparam int FW = 8;
    localparam int PW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            gen_en = 1'b0;
    logic            hs_mode = 1'b0;
    logic            hs_phase = 1'b0;
    logic [PW-1:0]   prescale = '0;
    logic [2*FW-1:0] low_cfg = '0;
    logic [2*FW-1:0] high_cfg = '0;
    logic            scl_pull_low, scl_fall_stb, scl_rise_stb;

    scl_timing_gen #(.FIELD_W(FW), .PSC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .hs_mode(hs_mode),
        .hs_phase(hs_phase), .prescale(prescale), .low_cfg(low_cfg),
        .high_cfg(high_cfg), .scl_pull_low(scl_pull_low),
        .scl_fall_stb(scl_fall_stb), .scl_rise_stb(scl_rise_stb)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_active = 0, m_low = 0, m_hs = 0, m_rem = 0;
    bit e_pull = 0, e_fall = 0, e_rise = 0;

    function automatic int phase_cycles(int cfg, int hs, int psc);
        int f;
        f = hs ? ((cfg >> FW) & ((1 << FW) - 1)) : (cfg & ((1 << FW) - 1));
        return hs ? (f + 6) : ((psc + 1) * (f + 6));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_low = 0; m_hs = 0; m_rem = 0;
            e_pull = 0; e_fall = 0; e_rise = 0;
        end else begin
            e_fall = 0; e_rise = 0;
            if (!gen_en) begin
                m_active = 0; m_hs = 0; m_low = 0; e_pull = 0;
            end else if (m_active == 0) begin
                m_active = 1; m_low = 1; m_hs = 0;
                m_rem = phase_cycles(int'(low_cfg), 0, int'(prescale));
                e_pull = 1; e_fall = 1;
            end else begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    if (m_low == 1) begin
                        m_low = 0;
                        m_hs = (hs_mode && hs_phase) ? 1 : 0;
                        m_rem = phase_cycles(int'(high_cfg), m_hs, int'(prescale));
                        e_pull = 0; e_rise = 1;
                    end else begin
                        m_low = 1;
                        m_rem = phase_cycles(int'(low_cfg), m_hs, int'(prescale));
                        e_pull = 1; e_fall = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if ({scl_pull_low, scl_fall_stb, scl_rise_stb} !== {e_pull, e_fall, e_rise}) begin
            n_bad++;
            $display("FAIL %s cycle %0d: pull/fall/rise actual %b%b%b expected %b%b%b",
                     cur_req, cyc, scl_pull_low, scl_fall_stb, scl_rise_stb,
                     e_pull, e_fall, e_rise);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state and idle with a configuration present
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        prescale = 8'd1; low_cfg = 16'h0302; high_cfg = 16'h0401;
        run(10);

        // R2 R3 R4: undivided standard timing
        cur_req = "R2";
        prescale = 8'd0; low_cfg = 16'h0002; high_cfg = 16'h0004;
        gen_en = 1'b1;
        run(4);
        cur_req = "R3";
        run(60);
        cur_req = "R4";
        prescale = 8'd2;
        run(150);

        // R6: mid-phase configuration changes
        cur_req = "R6";
        gen_en = 1'b0; run(2);
        prescale = 8'd1; low_cfg = 16'h0003; high_cfg = 16'h0005;
        gen_en = 1'b1; run(5);
        prescale = 8'd3; low_cfg = 16'h0001; high_cfg = 16'h0000;
        run(23);
        low_cfg = 16'h0006;
        run(120);

        // R7: stage select without high-speed mode
        cur_req = "R7";
        hs_mode = 1'b0; hs_phase = 1'b1;
        prescale = 8'd1; low_cfg = 16'h0902; high_cfg = 16'h0a03;
        run(120);

        // R8: high-speed stage, divider bypassed, upper-byte fields
        cur_req = "R8";
        prescale = 8'd3; low_cfg = 16'h0503; high_cfg = 16'h0702;
        hs_mode = 1'b1; hs_phase = 1'b1;
        run(200);
        hs_phase = 1'b0;
        run(200);

        // R9: stage select toggled at arbitrary times
        cur_req = "R9";
        prescale = 8'd0; low_cfg = 16'h0102; high_cfg = 16'h0201;
        for (int i = 0; i < 60; i++) begin
            hs_phase = ~hs_phase;
            run(3 + (i % 5));
        end

        // R1 again: disable mid-phase, then restart (R2)
        cur_req = "R1";
        gen_en = 1'b0; run(8);
        cur_req = "R2";
        hs_mode = 1'b0; hs_phase = 1'b0;
        gen_en = 1'b1; run(3);
        gen_en = 1'b0; run(1);
        gen_en = 1'b1; run(40);

        // R3: widest low field without division
        cur_req = "R3";
        gen_en = 1'b0; run(2);
        prescale = 8'd0; low_cfg = 16'h00ff; high_cfg = 16'h0001;
        gen_en = 1'b1; run(560);

        // R5: strobes across a long run of short phases
        cur_req = "R5";
        low_cfg = 16'h0000; high_cfg = 16'h0000;
        run(80);

        gen_en = 1'b0;
        run(4);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule